// File: doc/BRIEF.md
# Banked Code Fetch Mapper

This block turns the processor's 16-bit instruction-fetch address into a physical location in flash or in SRAM. The lower half of the fetch space is a fixed window onto the first 32 KB of flash. The upper half is a 32 KB window onto one flash bank, chosen by a 3-bit bank number held in a small configuration register. When the overlay bit in that register is set, SRAM covers the bottom of the upper window, so code can run out of RAM. The flash above the SRAM still follows the selected bank.

A second, independent path places the 8-bit internal-data address onto the highest 256 bytes of SRAM. Both arrays sit outside the block. The mapper drives their addresses and passes the returned byte through to the fetch data output. Where no storage answers, it returns zero instead. The number of flash banks and the SRAM size are parameters. A build with a single bank has nothing to show in the upper window except the SRAM overlay.

Top module: `cwm_mapper`

## Requirements
- R1: A fetch address below 0x8000 selects flash (fetch_target = 2'b01), and flash_addr equals the address.
- R2: A fetch at or above 0x8000 that misses the overlay selects flash when FLASH_BANKS > 1 and the bank number is below FLASH_BANKS. In that case flash_addr = bank × 0x8000 + (address − 0x8000).
- R3: With FLASH_BANKS = 1, a fetch at or above 0x8000 that misses the overlay selects nothing (fetch_target = 2'b00) and fetch_data is 0x00.
- R4: A fetch at or above 0x8000 that misses the overlay while the bank number is FLASH_BANKS or more selects nothing, and fetch_data is 0x00.
- R5: With the overlay bit set, a fetch with 0x8000 ≤ address < 0x8000 + SRAM_BYTES selects SRAM (fetch_target = 2'b10) with sram_addr = address − 0x8000. This applies whatever the bank number is.
- R6: With the overlay bit set, fetches from 0x8000 + SRAM_BYTES up to 0xFFFF follow R2, R3 and R4 exactly as with the overlay bit clear.
- R7: idata_sram_addr always equals SRAM_BYTES − 256 + idata_addr.
- R8: When cfg_we is high at a rising clock edge, cfg_bank and cfg_ovl are loaded, and the mapping uses them from that edge on. When cfg_we is low, the held values do not change.
- R9: After reset the register holds bank 0 with the overlay bit clear.
- R10: fetch_data carries flash_rdata when flash is selected, sram_rdata when SRAM is selected, and 0x00 otherwise. The address output of an array that is not selected is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load enable for the bank/overlay register |
| cfg_bank | input | 3 | Bank number for the upper window |
| cfg_ovl | input | 1 | SRAM overlay enable |
| fetch_addr | input | 16 | Instruction-fetch address |
| fetch_target | output | 2 | 00 none, 01 flash, 10 SRAM |
| flash_addr | output | FA_W | Physical flash byte address |
| sram_addr | output | SA_W | Physical SRAM byte address for the fetch |
| flash_rdata | input | 8 | Byte returned by the flash array |
| sram_rdata | input | 8 | Byte returned by the SRAM array for sram_addr |
| fetch_data | output | 8 | Fetched byte |
| idata_addr | input | 8 | Internal-data address |
| idata_sram_addr | output | SA_W | SRAM address for the internal-data access |

## Verification
The assertions assume that cfg_bank, cfg_ovl and cfg_we are driven to known values from the first clock edge. They also assume that fetch_addr changes only between edges. The bench meets both conditions by setting every input before reset is released and by changing the register inputs only at falling edges. The assertions also assume that SRAM_BYTES lies between 256 and 32768, which both instances in the bench respect. The array data inputs are modelled as pure functions of the addresses the block drives, so the data checks cannot match by accident of timing.

// File: rtl/cwm_pkg.sv
`timescale 1ns/1ps
package cwm_pkg;

    localparam int WIN_BYTES  = 32768;
    localparam int BANK_SEL_W = 3;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'b00,
        TGT_FLASH = 2'b01,
        TGT_SRAM  = 2'b10
    } tgt_e;

    typedef struct packed {
        logic [BANK_SEL_W-1:0] bank;
        logic                  ovl;
    } map_cfg_t;

    // Offset of a fetch inside the upper window.
    function automatic logic [14:0] window_off(input logic [15:0] a);
        return a[14:0];
    endfunction

    // Concatenated bank/offset form of a flash location.
    function automatic logic [17:0] banked_loc(input logic [BANK_SEL_W-1:0] b,
                                               input logic [14:0] off);
        return {b, off};
    endfunction

endpackage

// File: rtl/cwm_cfg_reg.sv
`timescale 1ns/1ps
module cwm_cfg_reg
    import cwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_we,
    input  map_cfg_t cfg_in,
    output map_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_in;
        end
    end

    p_cfg_load_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_q == $past(cfg_in)));

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q));

    p_cfg_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_q.bank == '0 && !cfg_q.ovl));

endmodule

// File: rtl/cwm_fetch_decode.sv
`timescale 1ns/1ps
module cwm_fetch_decode
    import cwm_pkg::*;
#(
    parameter int FLASH_BANKS = 4,
    parameter int SRAM_BYTES  = 8192,
    parameter int FA_W        = 17,
    parameter int SA_W        = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [15:0]     fetch_addr,
    input  map_cfg_t        cfg,
    output tgt_e            tgt,
    output logic [FA_W-1:0] flash_addr,
    output logic [SA_W-1:0] sram_addr
);

    localparam logic [15:0] SRAM_LIM = 16'(SRAM_BYTES);
    localparam logic [3:0]  BANK_LIM = 4'(FLASH_BANKS);

    logic [14:0] off;
    logic        upper;
    logic        ovl_hit;
    logic        bank_ok;

    assign off     = window_off(fetch_addr);
    assign upper   = fetch_addr[15];
    assign ovl_hit = cfg.ovl && ({1'b0, off} < SRAM_LIM);

    generate
        if (FLASH_BANKS > 1) begin : g_banked
            assign bank_ok = ({1'b0, cfg.bank} < BANK_LIM);
        end else begin : g_single
            assign bank_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        tgt        = TGT_NONE;
        flash_addr = '0;
        sram_addr  = '0;
        if (!upper) begin
            tgt        = TGT_FLASH;
            flash_addr = FA_W'(off);
        end else if (ovl_hit) begin
            tgt       = TGT_SRAM;
            sram_addr = SA_W'(off);
        end else if (bank_ok) begin
            tgt        = TGT_FLASH;
            flash_addr = FA_W'(banked_loc(cfg.bank, off));
        end
    end

    p_common_flash_r1: assert property (@(posedge clk) disable iff (rst)
        !fetch_addr[15] |-> (tgt == TGT_FLASH && flash_addr[14:0] == fetch_addr[14:0]));

    p_sram_only_overlay_r5: assert property (@(posedge clk) disable iff (rst)
        (tgt == TGT_SRAM) |-> (fetch_addr[15] && cfg.ovl));

    p_bad_bank_none_r4: assert property (@(posedge clk) disable iff (rst)
        (fetch_addr[15] && !cfg.ovl && ({1'b0, cfg.bank} >= BANK_LIM)) |-> (tgt == TGT_NONE));

    p_single_bank_r3: assert property (@(posedge clk) disable iff (rst)
        (FLASH_BANKS == 1 && fetch_addr[15]) |-> (tgt != TGT_FLASH));

endmodule

// File: rtl/cwm_idata_map.sv
`timescale 1ns/1ps
module cwm_idata_map #(
    parameter int SRAM_BYTES = 8192,
    parameter int SA_W       = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [7:0]      idata_addr,
    output logic [SA_W-1:0] idata_sram_addr
);

    localparam logic [SA_W-1:0] TOP_BASE = SA_W'(SRAM_BYTES - 256);

    assign idata_sram_addr = TOP_BASE + SA_W'(idata_addr);

    p_idata_top_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(idata_sram_addr) >= SRAM_BYTES - 256) && (int'(idata_sram_addr) < SRAM_BYTES));

endmodule

// File: rtl/cwm_byte_mux.sv
`timescale 1ns/1ps
module cwm_byte_mux
    import cwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tgt_e       tgt,
    input  logic [7:0] flash_rdata,
    input  logic [7:0] sram_rdata,
    output logic [7:0] fetch_data
);

    always_comb begin
        unique case (tgt)
            TGT_FLASH: fetch_data = flash_rdata;
            TGT_SRAM:  fetch_data = sram_rdata;
            default:   fetch_data = 8'h00;
        endcase
    end

    p_none_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (tgt != TGT_FLASH && tgt != TGT_SRAM) |-> (fetch_data == 8'h00));

endmodule

// File: rtl/cwm_mapper.sv
`timescale 1ns/1ps
module cwm_mapper
    import cwm_pkg::*;
#(
    parameter int FLASH_BANKS = 4,
    parameter int SRAM_BYTES  = 8192,
    localparam int FA_W       = $clog2(FLASH_BANKS * WIN_BYTES),
    localparam int SA_W       = $clog2(SRAM_BYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_bank,
    input  logic            cfg_ovl,
    input  logic [15:0]     fetch_addr,
    output logic [1:0]      fetch_target,
    output logic [FA_W-1:0] flash_addr,
    output logic [SA_W-1:0] sram_addr,
    input  logic [7:0]      flash_rdata,
    input  logic [7:0]      sram_rdata,
    output logic [7:0]      fetch_data,
    input  logic [7:0]      idata_addr,
    output logic [SA_W-1:0] idata_sram_addr
);

    map_cfg_t cfg_in;
    map_cfg_t cfg_q;
    tgt_e     tgt;

    assign cfg_in.bank = cfg_bank;
    assign cfg_in.ovl  = cfg_ovl;

    cwm_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_we (cfg_we),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    cwm_fetch_decode #(
        .FLASH_BANKS (FLASH_BANKS),
        .SRAM_BYTES  (SRAM_BYTES),
        .FA_W        (FA_W),
        .SA_W        (SA_W)
    ) u_dec (
        .clk        (clk),
        .rst        (rst),
        .fetch_addr (fetch_addr),
        .cfg        (cfg_q),
        .tgt        (tgt),
        .flash_addr (flash_addr),
        .sram_addr  (sram_addr)
    );

    cwm_byte_mux u_mux (
        .clk         (clk),
        .rst         (rst),
        .tgt         (tgt),
        .flash_rdata (flash_rdata),
        .sram_rdata  (sram_rdata),
        .fetch_data  (fetch_data)
    );

    cwm_idata_map #(
        .SRAM_BYTES (SRAM_BYTES),
        .SA_W       (SA_W)
    ) u_idata (
        .clk             (clk),
        .rst             (rst),
        .idata_addr      (idata_addr),
        .idata_sram_addr (idata_sram_addr)
    );

    assign fetch_target = tgt;

    p_unused_addr_zero_r10: assert property (@(posedge clk) disable iff (rst)
        ((fetch_target != 2'b01) |-> (flash_addr == '0)) and
        ((fetch_target != 2'b10) |-> (sram_addr == '0)));

    p_overlay_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (fetch_target == 2'b01 && fetch_addr[15]) |-> (flash_addr[14:0] == fetch_addr[14:0]));

endmodule

// File: tb/cwm_mapper_test.sv
`timescale 1ns/1ps
module cwm_mapper_test;

    localparam int BIG_BANKS = 4;
    localparam int BIG_SRAM  = 8192;
    localparam int SM_BANKS  = 1;
    localparam int SM_SRAM   = 4096;
    localparam int BFA_W = $clog2(BIG_BANKS * 32768);
    localparam int BSA_W = $clog2(BIG_SRAM);
    localparam int SFA_W = $clog2(SM_BANKS * 32768);
    localparam int SSA_W = $clog2(SM_SRAM);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_bank = 3'd0;
    logic cfg_ovl = 1'b0;
    logic [15:0] fetch_addr = 16'h0;
    logic [7:0] idata_addr = 8'h0;

    logic [1:0] b_tgt, s_tgt;
    logic [BFA_W-1:0] b_fa;
    logic [BSA_W-1:0] b_sa, b_ia;
    logic [SFA_W-1:0] s_fa;
    logic [SSA_W-1:0] s_sa, s_ia;
    logic [7:0] b_frd, b_srd, b_dat, s_frd, s_srd, s_dat;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int cur_bank = 0;
    int cur_ovl = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] fhash(input int a);
        return 8'((a * 37 + 11) ^ (a >> 9));
    endfunction
    function automatic logic [7:0] shash(input int a);
        return 8'(a * 53 + 165);
    endfunction

    assign b_frd = fhash(int'(b_fa));
    assign b_srd = shash(int'(b_sa));
    assign s_frd = fhash(int'(s_fa));
    assign s_srd = shash(int'(s_sa));

    cwm_mapper #(.FLASH_BANKS(BIG_BANKS), .SRAM_BYTES(BIG_SRAM)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_ovl(cfg_ovl),
        .fetch_addr(fetch_addr), .fetch_target(b_tgt), .flash_addr(b_fa), .sram_addr(b_sa),
        .flash_rdata(b_frd), .sram_rdata(b_srd), .fetch_data(b_dat),
        .idata_addr(idata_addr), .idata_sram_addr(b_ia));

    cwm_mapper #(.FLASH_BANKS(SM_BANKS), .SRAM_BYTES(SM_SRAM)) uut_small (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_ovl(cfg_ovl),
        .fetch_addr(fetch_addr), .fetch_target(s_tgt), .flash_addr(s_fa), .sram_addr(s_sa),
        .flash_rdata(s_frd), .sram_rdata(s_srd), .fetch_data(s_dat),
        .idata_addr(idata_addr), .idata_sram_addr(s_ia));

    // Expected mapping computed from R1..R6.
    task automatic model(input int a, input int bank, input int ovl, input int banks,
                         input int sram, output int tgt, output int fa, output int sa,
                         output string tag);
        int off;
        tgt = 0; fa = 0; sa = 0;
        if (a < 32768) begin
            tgt = 1; fa = a; tag = "R1";
        end else begin
            off = a - 32768;
            if (ovl != 0 && off < sram) begin
                tgt = 2; sa = off; tag = "R5";
            end else if (banks > 1 && bank < banks) begin
                tgt = 1; fa = bank * 32768 + off; tag = (ovl != 0) ? "R6" : "R2";
            end else begin
                tag = (banks == 1) ? "R3" : "R4";
            end
        end
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s addr=%h bank=%0d ovl=%0d actual=%0h expected=%0h",
                     tag, what, fetch_addr, cur_bank, cur_ovl, act, exp);
        end
    endtask

    task automatic check_fetch(input int a);
        int tgt, fa, sa, dat;
        string tag;
        fetch_addr = 16'(a);
        #1;
        model(a, cur_bank, cur_ovl, BIG_BANKS, BIG_SRAM, tgt, fa, sa, tag);
        dat = (tgt == 1) ? int'(fhash(fa)) : (tgt == 2) ? int'(shash(sa)) : 0;
        cmp(tag, "big target", int'(b_tgt), tgt);
        cmp(tag, "big flash_addr", int'(b_fa), fa);
        cmp(tag, "big sram_addr", int'(b_sa), sa);
        cmp("R10", "big data", int'(b_dat), dat);
        model(a, cur_bank, cur_ovl, SM_BANKS, SM_SRAM, tgt, fa, sa, tag);
        dat = (tgt == 1) ? int'(fhash(fa)) : (tgt == 2) ? int'(shash(sa)) : 0;
        cmp(tag, "small target", int'(s_tgt), tgt);
        cmp(tag, "small flash_addr", int'(s_fa), fa);
        cmp(tag, "small sram_addr", int'(s_sa), sa);
        cmp("R10", "small data", int'(s_dat), dat);
    endtask

    task automatic write_cfg(input int bank, input int ovl, input bit we);
        @(negedge clk);
        cfg_we = we;
        cfg_bank = 3'(bank);
        cfg_ovl = ovl[0];
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (we) begin
            cur_bank = bank;
            cur_ovl = ovl;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: reset leaves bank 0, overlay off
        check_fetch(16'h8000);
        check_fetch(16'h9234);
        cmp("R9", "big target after reset", int'(b_tgt), 1);
        cmp("R9", "small target after reset", int'(s_tgt), 0);

        // R8: write takes effect at the edge, not before
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 3'd2; cfg_ovl = 1'b1;
        fetch_addr = 16'h8010;
        #1;
        cmp("R8", "before edge target", int'(b_tgt), 1);
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        cur_bank = 2; cur_ovl = 1;
        cmp("R8", "after edge target", int'(b_tgt), 2);
        check_fetch(16'h8010);
        // R8: cfg_we low means inputs ignored
        write_cfg(5, 0, 1'b0);
        check_fetch(16'h8010);
        check_fetch(16'hA000);

        // Sweep all banks and overlay settings (R1..R6, R10)
        for (int ov = 0; ov < 2; ov++) begin
            for (int bk = 0; bk < 8; bk++) begin
                write_cfg(bk, ov, 1'b1);
                for (int a = 0; a < 65536; a += 61) check_fetch(a);
                check_fetch(16'h0000);
                check_fetch(16'h7FFF);
                check_fetch(16'h8000);
                check_fetch(32768 + SM_SRAM - 1);
                check_fetch(32768 + SM_SRAM);
                check_fetch(32768 + BIG_SRAM - 1);
                check_fetch(32768 + BIG_SRAM);
                check_fetch(16'hFFFF);
            end
        end

        // Full address sweep for one overlay configuration
        write_cfg(3, 1, 1'b1);
        for (int a = 0; a < 65536; a++) check_fetch(a);

        // R7: internal-data mapping
        for (int i = 0; i < 256; i++) begin
            idata_addr = 8'(i);
            #1;
            cmp("R7", "big idata", int'(b_ia), BIG_SRAM - 256 + i);
            cmp("R7", "small idata", int'(s_ia), SM_SRAM - 256 + i);
        end

        finish_run();
    end

endmodule